// File: doc/BRIEF.md
# Serial EEPROM Sequential Read Engine

This block is a two-wire bus master that reads bytes from a serial EEPROM. It assumes the EEPROM's internal address pointer has already been set. A command pulse starts one transfer. The engine sends a start condition, then a control byte marked as a read. After that it shifts in the requested number of data bytes, most significant bit first. Each byte appears on a parallel output together with a one-cycle strobe.

The master acknowledges every received byte except the last one. The last byte gets a no-acknowledge, and a stop condition closes the transfer. Two EEPROM addressing styles are supported:
- In the narrow style, the three select bits of the control byte carry the top three bits of the memory address.
- In the wide style, those three bits are sent as zero.

If the EEPROM does not acknowledge the control byte, the transfer is abandoned and a stop is sent. A timeout flag is then set, and it stays set until it is cleared explicitly.

The bus clock comes from the system clock through a divider. Each bus bit has four phases of `CLK_DIV` system cycles. The two bus lines are open-drain: the block only drives each line low or releases it. The data line's level is read back through `sdaIn`.

Top module: `eepromSeqRead`

## Requirements
- R1: After a start condition (SDA falls while SCL is high), the first byte on SDA is sent MSB first. In narrow mode (`cmdWide`=0) its value is {1010, cmdAddrHi[2], cmdAddrHi[1], cmdAddrHi[0], 1}. Bits 7..4 are the code 1010, bits 3..1 hold the upper address bits (A10 down to A8), and bit 0 is the read flag, high.
- R2: In wide mode (`cmdWide`=1), bits 3..1 of the control byte are 000, whatever `cmdAddrHi` holds. The rest of the byte is the same as in R1.
- R3: If SDA is high when the acknowledge bit after the control byte is sampled, the transfer is aborted:
  - no data byte is presented;
  - `timeout` rises;
  - a stop condition is sent;
  - `done` pulses.
- R4: `timeout` stays high across later transfers until `timeoutClr` is asserted. Asserting `timeoutClr` clears it.
- R5: Each data byte is assembled MSB first from SDA levels sampled while SCL is high. It is presented on `rdData` with `rdValid` high for exactly one cycle.
- R6: After every data byte except the last, the master drives SDA low for the acknowledge bit. After the last byte it leaves SDA released (no-acknowledge) and then sends a stop condition.
- R7: A transfer delivers `cmdCount` bytes. A count of 0 delivers one byte.
- R8: Each command produces exactly one start and one stop condition. SDA changes while SCL is high only to form those two conditions.
- R9: `busy` is high from the cycle after an accepted `cmdStart` until the single-cycle `done` pulse, which coincides with `busy` going low. A `cmdStart` while busy is ignored.
- R10: Out of reset:
  - both line drivers are released;
  - `busy`, `done`, `rdValid` and `timeout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Start a read transfer (accepted when idle) |
| cmdCount | input | CNT_W | Number of bytes to read, 0 means 1 |
| cmdWide | input | 1 | 1: wide addressing (select bits 000), 0: narrow (select bits carry A10..A8) |
| cmdAddrHi | input | 3 | Upper address bits A10..A8 for narrow mode |
| timeoutClr | input | 1 | Clears the sticky timeout flag |
| sdaIn | input | 1 | Sampled level of the SDA line |
| sclDriveLow | output | 1 | Pull SCL low when 1, release when 0 |
| sdaDriveLow | output | 1 | Pull SDA low when 1, release when 0 |
| rdData | output | 8 | Last received data byte |
| rdValid | output | 1 | One-cycle strobe for a new `rdData` byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| timeout | output | 1 | Sticky flag: the control byte was not acknowledged |

## Verification
The assertions assume the following about the environment:
- The SCL line follows the block's own driver, so no device stretches the clock.
- `CLK_DIV` is at least 2, so the released SCL level is settled before the sampling tick.
- The slave only ever pulls SDA low, and only during acknowledge and data bits.

The bench's slave model meets these assumptions. It watches the bus and changes its SDA pull only one cycle after it sees SCL fall. It drives only the control-byte acknowledge and the data bits. It lets go as soon as it has seen the master's no-acknowledge, so the stop condition is never disturbed.

// File: rtl/eepromRdPkg.sv
package eepromRdPkg;

  localparam logic [3:0] CTRL_CODE = 4'b1010;

  // Kind of bus bit slot currently being generated; also the sequencer state.
  typedef enum logic [2:0] {
    SLOT_IDLE,
    SLOT_START,
    SLOT_TX,
    SLOT_CACK,
    SLOT_RX,
    SLOT_MACK,
    SLOT_MNACK,
    SLOT_STOP
  } slotKindT;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    slotKindT slot;
    logic     loadCtrl;
    logic     shiftTx;
    logic     captureRx;
    logic     emitByte;
  } busStrobesT;

endpackage

// File: rtl/eepromBitTimer.sv
module eepromBitTimer #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  output logic       tick,
  output logic [1:0] phase
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] divCnt;

  initial begin
    if (CLK_DIV < 2) $error("CLK_DIV must be at least 2");
  end

  assign tick = run && (divCnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      divCnt <= '0;
      phase  <= 2'd0;
    end else if (tick) begin
      divCnt <= '0;
      phase  <= phase + 2'd1;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  // Idle timer sits at the first phase
  AST_PHASE_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (phase == 2'd0)); // R8

endmodule

// File: rtl/eepromRdDatapath.sv
module eepromRdDatapath
  import eepromRdPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  busStrobesT strobes,
  input  logic [1:0] phase,
  input  logic       cmdWide,
  input  logic [2:0] cmdAddrHi,
  input  logic       sdaIn,
  output logic       sampledBit,
  output logic       sclDrv,
  output logic       sdaDrv,
  output logic [7:0] rdData,
  output logic       rdValid
);

  logic [7:0] txShift;
  logic [7:0] rxShift;
  logic       sclNext;
  logic       sdaNext;
  logic       lowHalf;

  assign lowHalf = !phase[1];

  // Line drive for the next cycle, from slot kind and phase.
  always_comb begin
    sclNext = 1'b0;
    sdaNext = sdaDrv;
    unique case (strobes.slot)
      SLOT_IDLE:  sdaNext = 1'b0;
      SLOT_START: sdaNext = phase[1];
      SLOT_TX: begin
        sclNext = lowHalf;
        if (phase != 2'd0) sdaNext = !txShift[7];
      end
      SLOT_CACK, SLOT_RX: begin
        sclNext = lowHalf;
        if (phase != 2'd0) sdaNext = 1'b0;
      end
      SLOT_MACK: begin
        sclNext = lowHalf;
        if (phase != 2'd0) sdaNext = 1'b1;
      end
      SLOT_MNACK: begin
        sclNext = lowHalf;
        if (phase != 2'd0) sdaNext = 1'b0;
      end
      SLOT_STOP: begin
        sclNext = lowHalf;
        if (phase != 2'd0) sdaNext = (phase != 2'd3);
      end
      default: begin
        sclNext = 1'b0;
        sdaNext = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclDrv <= 1'b0;
      sdaDrv <= 1'b0;
    end else begin
      sclDrv <= sclNext;
      sdaDrv <= sdaNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strobes.loadCtrl) begin
      txShift <= {CTRL_CODE, (cmdWide ? 3'b000 : cmdAddrHi), 1'b1};
    end else if (strobes.shiftTx) begin
      txShift <= {txShift[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift    <= '0;
      sampledBit <= 1'b0;
    end else if (strobes.captureRx) begin
      sampledBit <= sdaIn;
      if (strobes.slot == SLOT_RX) rxShift <= {rxShift[6:0], sdaIn};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobes.emitByte;
      if (strobes.emitByte) rdData <= rxShift;
    end
  end

  AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ((sdaDrv != $past(sdaDrv)) && !sclDrv && !$past(sclDrv))
      |-> ($past(strobes.slot) == SLOT_START || $past(strobes.slot) == SLOT_STOP)); // R8

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R5

  AST_CTRL_READ_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.slot == SLOT_START) |-> (txShift[7:4] == CTRL_CODE && txShift[0])); // R1

  AST_NACK_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.slot) == SLOT_MNACK && !sclDrv) |-> !sdaDrv); // R6

endmodule

// File: rtl/eepromRdSequencer.sv
module eepromRdSequencer
  import eepromRdPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdStart,
  input  logic [CNT_W-1:0] cmdCount,
  input  logic             timeoutClr,
  input  logic             tick,
  input  logic [1:0]       phase,
  input  logic             sampledBit,
  output busStrobesT       strobes,
  output logic             busy,
  output logic             done,
  output logic             timeoutFlag
);

  slotKindT         state;
  logic [2:0]       bitCnt;
  logic [CNT_W-1:0] bytesLeft;
  logic             slotEnd;
  logic             midHigh;

  assign slotEnd = tick && (phase == 2'd3);
  assign midHigh = tick && (phase == 2'd2);
  assign busy    = (state != SLOT_IDLE);

  always_comb begin
    strobes.slot      = state;
    strobes.loadCtrl  = (state == SLOT_IDLE) && cmdStart;
    strobes.shiftTx   = slotEnd && (state == SLOT_TX);
    strobes.captureRx = midHigh && (state == SLOT_RX || state == SLOT_CACK);
    strobes.emitByte  = slotEnd && (state == SLOT_RX) && (bitCnt == 3'd7);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= SLOT_IDLE;
      bitCnt      <= '0;
      bytesLeft   <= '0;
      done        <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      done <= 1'b0;
      if (timeoutClr) timeoutFlag <= 1'b0;
      if (state == SLOT_IDLE) begin
        if (cmdStart) begin
          state     <= SLOT_START;
          bitCnt    <= '0;
          bytesLeft <= (cmdCount == '0) ? CNT_W'(1) : cmdCount;
        end
      end else if (slotEnd) begin
        unique case (state)
          SLOT_START: begin
            state  <= SLOT_TX;
            bitCnt <= '0;
          end
          SLOT_TX: begin
            if (bitCnt == 3'd7) state <= SLOT_CACK;
            bitCnt <= bitCnt + 3'd1;
          end
          SLOT_CACK: begin
            bitCnt <= '0;
            if (sampledBit) begin
              state       <= SLOT_STOP;
              timeoutFlag <= 1'b1;
            end else begin
              state <= SLOT_RX;
            end
          end
          SLOT_RX: begin
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              bytesLeft <= bytesLeft - CNT_W'(1);
              state     <= (bytesLeft == CNT_W'(1)) ? SLOT_MNACK : SLOT_MACK;
            end
          end
          SLOT_MACK:  state <= SLOT_RX;
          SLOT_MNACK: state <= SLOT_STOP;
          SLOT_STOP: begin
            state <= SLOT_IDLE;
            done  <= 1'b1;
          end
          default: state <= SLOT_IDLE;
        endcase
      end
    end
  end

  AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    (state == SLOT_RX || state == SLOT_MACK) |-> (bytesLeft != '0)); // R7

  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !timeoutClr) |=> timeoutFlag); // R4

  AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> (state == SLOT_STOP)); // R3

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (state == SLOT_IDLE && $past(state) == SLOT_STOP)); // R9

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    (busy && state != SLOT_STOP && cmdStart) |=> busy); // R9

endmodule

// File: rtl/eepromSeqRead.sv
module eepromSeqRead
  import eepromRdPkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdStart,
  input  logic [CNT_W-1:0] cmdCount,
  input  logic             cmdWide,
  input  logic [2:0]       cmdAddrHi,
  input  logic             timeoutClr,
  input  logic             sdaIn,
  output logic             sclDriveLow,
  output logic             sdaDriveLow,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic             busy,
  output logic             done,
  output logic             timeout
);

  busStrobesT strobes;
  logic       tick;
  logic [1:0] phase;
  logic       sampledBit;

  eepromBitTimer #(.CLK_DIV(CLK_DIV)) u_timer (
    .clk   (clk),
    .rstN  (rstN),
    .run   (busy),
    .tick  (tick),
    .phase (phase)
  );

  eepromRdSequencer #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rstN        (rstN),
    .cmdStart    (cmdStart),
    .cmdCount    (cmdCount),
    .timeoutClr  (timeoutClr),
    .tick        (tick),
    .phase       (phase),
    .sampledBit  (sampledBit),
    .strobes     (strobes),
    .busy        (busy),
    .done        (done),
    .timeoutFlag (timeout)
  );

  eepromRdDatapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .phase      (phase),
    .cmdWide    (cmdWide),
    .cmdAddrHi  (cmdAddrHi),
    .sdaIn      (sdaIn),
    .sampledBit (sampledBit),
    .sclDrv     (sclDriveLow),
    .sdaDrv     (sdaDriveLow),
    .rdData     (rdData),
    .rdValid    (rdValid)
  );

endmodule

// File: tb/eepromSeqRead_tb.sv
module eepromSeqRead_tb;

  localparam int DIV = 2;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cmdStart, cmdWide, timeoutClr;
  logic [7:0] cmdCount;
  logic [2:0] cmdAddrHi;
  logic       sclDriveLow, sdaDriveLow, rdValid, busy, done, timeout;
  logic [7:0] rdData;
  logic       slvLow = 1'b0;
  logic       sclLine, sdaLine;

  always #2 clk = ~clk;

  assign sclLine = !sclDriveLow;
  assign sdaLine = !(sdaDriveLow || slvLow);

  eepromSeqRead #(.CLK_DIV(DIV), .CNT_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdCount(cmdCount),
    .cmdWide(cmdWide), .cmdAddrHi(cmdAddrHi), .timeoutClr(timeoutClr),
    .sdaIn(sdaLine), .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .rdData(rdData), .rdValid(rdValid), .busy(busy), .done(done), .timeout(timeout)
  );

  int nChecks = 0;
  int nFail   = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int j, input logic [7:0] seed);
    return 8'((j * 37) + seed) ^ 8'(j << 5);
  endfunction

  // Slave model
  logic       prevScl = 1'b1, prevSda = 1'b1;
  bit         inXfer = 0, gotNack = 0, slvAckEn = 1;
  logic [7:0] slvSeed = 8'h00, ctrlShift = 8'h00, ctrlSeen = 8'h00;
  int         riseCnt = 0, startCnt = 0, stopCnt = 0;
  bit         ackLog [0:255];

  always @(posedge clk) begin
    if (prevScl && sclLine && prevSda && !sdaLine) begin
      startCnt++; inXfer = 1; riseCnt = 0; gotNack = 0; ctrlShift = 8'h00;
    end else if (prevScl && sclLine && !prevSda && sdaLine) begin
      stopCnt++; inXfer = 0; slvLow <= 1'b0;
    end else if (inXfer && !prevScl && sclLine) begin
      riseCnt++;
      if (riseCnt <= 8) ctrlShift = {ctrlShift[6:0], sdaLine};
      if (riseCnt == 8) ctrlSeen = ctrlShift;
      if (riseCnt >= 10 && ((riseCnt - 10) % 9) == 8) begin
        ackLog[(riseCnt - 10) / 9] = sdaLine;
        if (sdaLine) gotNack = 1;
      end
    end else if (inXfer && prevScl && !sclLine) begin
      int n;
      n = riseCnt + 1;
      if (!slvAckEn || gotNack) slvLow <= 1'b0;
      else if (n == 9) slvLow <= 1'b1;
      else if (n >= 10 && ((n - 10) % 9) < 8) begin
        logic [7:0] b;
        b = pat((n - 10) / 9, slvSeed);
        slvLow <= !b[7 - ((n - 10) % 9)];
      end else slvLow <= 1'b0;
    end
    prevScl = sclLine;
    prevSda = sdaLine;
  end

  // Byte monitor
  logic [7:0] rxLog [0:255];
  int         rxCnt = 0;
  always @(negedge clk) begin
    if (rdValid) begin
      if (rxCnt < 256) rxLog[rxCnt] = rdData;
      rxCnt++;
    end
  end

  task automatic runTxn(input int count, input bit wide, input logic [2:0] hi,
                        input bit ackEn, input logic [7:0] seed);
    int effN, cyc;
    logic [7:0] expCtrl;
    effN = (count == 0) ? 1 : count;
    expCtrl = {4'b1010, (wide ? 3'b000 : hi), 1'b1};
    @(negedge clk);
    slvAckEn = ackEn; slvSeed = seed;
    rxCnt = 0; startCnt = 0; stopCnt = 0;
    cmdCount = 8'(count); cmdWide = wide; cmdAddrHi = hi; cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    // a second command while busy must be ignored
    cmdStart = 1'b1; cmdWide = !wide; cmdAddrHi = hi ^ 3'b101; cmdCount = 8'd9;
    @(negedge clk);
    cmdStart = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (!done && !busy) break;
    end
    chk(done == 1'b1 && busy == 1'b0, "R9 done with busy low", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
    repeat (4) @(negedge clk);
    if (wide) chk(ctrlSeen == expCtrl, "R2 control byte", int'(ctrlSeen), int'(expCtrl));
    else      chk(ctrlSeen == expCtrl, "R1 control byte", int'(ctrlSeen), int'(expCtrl));
    chk(startCnt == 1, "R8 start count", startCnt, 1);
    chk(stopCnt == 1, "R8 stop count", stopCnt, 1);
    if (ackEn) begin
      chk(rxCnt == effN, "R7 byte count", rxCnt, effN);
      for (int j = 0; j < effN && j < rxCnt; j++) begin
        chk(rxLog[j] == pat(j, seed), "R5 data byte", int'(rxLog[j]), int'(pat(j, seed)));
        chk(ackLog[j] == (j == effN - 1), "R6 master ack bit", int'(ackLog[j]),
            (j == effN - 1) ? 1 : 0);
      end
    end else begin
      chk(rxCnt == 0, "R3 no data after abort", rxCnt, 0);
      chk(timeout == 1'b1, "R3 timeout set", int'(timeout), 1);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    rstN = 1'b0; cmdStart = 1'b0; cmdWide = 1'b0; cmdAddrHi = 3'd0;
    cmdCount = 8'd0; timeoutClr = 1'b0;
    repeat (5) @(negedge clk);
    chk(sclDriveLow == 1'b0 && sdaDriveLow == 1'b0, "R10 lines released",
        int'({sclDriveLow, sdaDriveLow}), 0);
    chk(busy == 1'b0 && done == 1'b0 && rdValid == 1'b0, "R10 status idle",
        int'({busy, done, rdValid}), 0);
    chk(timeout == 1'b0, "R10 timeout clear", int'(timeout), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    for (int w = 0; w < 2; w++)
      for (int h = 0; h < 8; h++)
        for (int c = 0; c < 4; c++)
          runTxn(c, w[0], 3'(h), 1'b1, 8'(h * 29 + c * 7 + w * 101));
    chk(timeout == 1'b0, "R4 no timeout when acknowledged", int'(timeout), 0);
    runTxn(17, 1'b0, 3'd6, 1'b1, 8'hC3);

    // aborted transfer, then sticky flag across a good one
    runTxn(2, 1'b0, 3'd5, 1'b0, 8'h11);
    runTxn(1, 1'b1, 3'd0, 1'b1, 8'h42);
    chk(timeout == 1'b1, "R4 timeout sticky", int'(timeout), 1);
    @(negedge clk); timeoutClr = 1'b1;
    @(negedge clk); timeoutClr = 1'b0;
    chk(timeout == 1'b0, "R4 timeout cleared", int'(timeout), 0);
    runTxn(3, 1'b1, 3'd7, 1'b0, 8'h77);
    @(negedge clk); timeoutClr = 1'b1;
    @(negedge clk); timeoutClr = 1'b0;
    chk(timeout == 1'b0, "R4 timeout cleared again", int'(timeout), 0);
    finishRun();
  end

endmodule